// File: doc/BRIEF.md
# Bit-Serial Operate Microsequencer

This block runs the accumulator-only "operate" class of instruction for a small accumulator machine. A start pulse captures the instruction's 11-bit operand field, the accumulator A, the program counter P and the link register L. The block then scans the low eight bits of that field, one bit per clock cycle, in a fixed order. Each set bit applies one operation to the working copies of A or P. Every operation sees the result of the operations scanned before it. The block makes no memory access.

When the scan ends, the block raises a one-cycle completion strobe. The updated A and P stay on its outputs until the next accepted start. The sequencer that issues the instruction starts the block and waits for the strobe, then writes A and P back.

Top module: `opsq_top`

## Requirements
- R1: While reset is asserted, busy_o, done_o, acc_o and pc_o are all zero.
- R2: A start_i sampled high while the block is idle is accepted. busy_o is high for exactly 8 cycles after that edge. done_o is high for exactly one cycle starting at the 8th clock edge after the accepting edge, and busy_o is low in that cycle.
- R3: Field bit 0 (negative test): if bit 13 of the working A is 1 when this bit is scanned, P is incremented by one.
- R4: Field bit 1 (zero test): if the working A equals zero when this bit is scanned, P is incremented by one.
- R5: Field bit 2 clears A to zero. Field bit 3 replaces A with its bitwise complement.
- R6: Field bit 4 adds one to A, wrapping modulo 2^14 (3FFF becomes 0000).
- R7: Field bit 5 shifts A left one place, and field bit 6 shifts A right one place. Both shifts are logical and fill with zero.
- R8: Field bit 7 loads P from the captured L, replacing any skip increments applied earlier in the scan.
- R9: Operations apply cumulatively in the order bit 0, 1, 2 … 7. Each one sees A and P as left by the bits before it.
- R10: Field bits 8, 9 and 10 have no effect on acc_o or pc_o.
- R11: start_i and the data inputs are ignored while busy_o is high. Neither the result nor the done_o timing changes.
- R12: After done_o, acc_o and pc_o hold their final values until the next accepted start. With an all-zero field they equal the captured A and P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to run one operate instruction |
| field_i | input | 11 | Operand field of the instruction |
| acc_i | input | 14 | Accumulator value at start |
| pc_i | input | 14 | Program counter at start (already pointing past this instruction) |
| link_i | input | 14 | Link register holding the subroutine return address |
| busy_o | output | 1 | High while the bit scan is running |
| done_o | output | 1 | One-cycle completion strobe |
| acc_o | output | 14 | Updated accumulator |
| pc_o | output | 14 | Updated program counter |

## Verification
The bench builds the block with its default parameters: a 14-bit data path and an 11-bit field. With a 14-bit data path, the wrap from 3FFF and a set bit 13 can be driven directly, so the increment overflow and the negative test both come up in directed cases. Random fields over the full 11 bits mix every combination of the eight operations with the three unused bits. Each result is compared with a bench model that applies the operations in scan order.

// File: rtl/opsq_pkg.sv
package opsq_pkg;

  // Number of field bits that carry an operation; scan order is bit 0 upward.
  localparam int unsigned NUM_OPS = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_OPS);

  typedef enum logic [IDX_W-1:0] {
    OP_TEST_NEG = 3'd0,
    OP_TEST_ZER = 3'd1,
    OP_CLEAR    = 3'd2,
    OP_INVERT   = 3'd3,
    OP_INCR     = 3'd4,
    OP_SHL      = 3'd5,
    OP_SHR      = 3'd6,
    OP_RETURN   = 3'd7
  } opsq_op_e;

endpackage

// File: rtl/opsq_scan_ctrl.sv
module opsq_scan_ctrl
  import opsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OPS - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_step;

  assign accept_o  = start_i & ~busy_q;
  assign step_o    = busy_q;
  assign last_step = busy_q & (idx_q == LAST_IDX);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = last_step;
    if (accept_o) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (last_step) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/opsq_step_alu.sv
module opsq_step_alu
  import opsq_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_OPS-1:0] ops_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic [DATA_W-1:0]  pc_i,
  input  logic [DATA_W-1:0]  link_i,
  output logic [DATA_W-1:0]  acc_o,
  output logic [DATA_W-1:0]  pc_o
);

  logic             bit_on;
  logic             acc_neg;
  logic             acc_zero;
  logic [DATA_W-1:0] pc_skip;
  opsq_op_e         op;

  assign op       = opsq_op_e'(idx_i);
  assign bit_on   = ops_i[idx_i];
  assign acc_neg  = acc_i[DATA_W-1];
  assign acc_zero = (acc_i == '0);
  assign pc_skip  = pc_i + DATA_W'(1);

  always_comb begin
    acc_o = acc_i;
    pc_o  = pc_i;
    if (bit_on) begin
      unique case (op)
        OP_TEST_NEG: if (acc_neg)  pc_o = pc_skip;
        OP_TEST_ZER: if (acc_zero) pc_o = pc_skip;
        OP_CLEAR:    acc_o = '0;
        OP_INVERT:   acc_o = ~acc_i;
        OP_INCR:     acc_o = acc_i + DATA_W'(1);
        OP_SHL:      acc_o = {acc_i[DATA_W-2:0], 1'b0};
        OP_SHR:      acc_o = {1'b0, acc_i[DATA_W-1:1]};
        OP_RETURN:   pc_o  = link_i;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/opsq_work_regs.sv
module opsq_work_regs
  import opsq_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               step_en,
  input  logic [NUM_OPS-1:0] ops_in,
  input  logic [DATA_W-1:0]  acc_in,
  input  logic [DATA_W-1:0]  pc_in,
  input  logic [DATA_W-1:0]  link_in,
  input  logic [DATA_W-1:0]  acc_step,
  input  logic [DATA_W-1:0]  pc_step,
  output logic [NUM_OPS-1:0] ops_q,
  output logic [DATA_W-1:0]  acc_q,
  output logic [DATA_W-1:0]  pc_q,
  output logic [DATA_W-1:0]  link_q
);

  logic [NUM_OPS-1:0] ops_d;
  logic [DATA_W-1:0]  acc_d, pc_d, link_d;

  always_comb begin
    ops_d  = ops_q;
    acc_d  = acc_q;
    pc_d   = pc_q;
    link_d = link_q;
    if (load_en) begin
      ops_d  = ops_in;
      acc_d  = acc_in;
      pc_d   = pc_in;
      link_d = link_in;
    end else if (step_en) begin
      acc_d = acc_step;
      pc_d  = pc_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ops_q  <= '0;
      acc_q  <= '0;
      pc_q   <= '0;
      link_q <= '0;
    end else begin
      ops_q  <= ops_d;
      acc_q  <= acc_d;
      pc_q   <= pc_d;
      link_q <= link_d;
    end
  end

endmodule

// File: rtl/opsq_top.sv
module opsq_top
  import opsq_pkg::*;
#(
  parameter int unsigned DATA_W  = 14,
  parameter int unsigned FIELD_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic [DATA_W-1:0]  pc_i,
  input  logic [DATA_W-1:0]  link_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  acc_o,
  output logic [DATA_W-1:0]  pc_o
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic               accept, step;
  logic [IDX_W-1:0]   idx;
  logic [NUM_OPS-1:0] field_q;
  logic [DATA_W-1:0]  acc_q, pc_q, link_q;
  logic [DATA_W-1:0]  acc_step, pc_step;

  opsq_scan_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step),
    .idx_o    (idx),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  opsq_step_alu #(.DATA_W(DATA_W)) u_alu (
    .idx_i  (idx),
    .ops_i  (field_q),
    .acc_i  (acc_q),
    .pc_i   (pc_q),
    .link_i (link_q),
    .acc_o  (acc_step),
    .pc_o   (pc_step)
  );

  opsq_work_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (accept),
    .step_en  (step),
    .ops_in   (field_i[NUM_OPS-1:0]),
    .acc_in   (acc_i),
    .pc_in    (pc_i),
    .link_in  (link_i),
    .acc_step (acc_step),
    .pc_step  (pc_step),
    .ops_q    (field_q),
    .acc_q    (acc_q),
    .pc_q     (pc_q),
    .link_q   (link_q)
  );

  // Upper field bits carry no operation and are dropped here.
  logic unused_hi;
  assign unused_hi = ^field_i[FIELD_W-1:NUM_OPS];

  assign acc_o = acc_q;
  assign pc_o  = pc_q;

endmodule

// File: rtl/opsq_chk.sv
module opsq_chk
  import opsq_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy_o,
  input logic               done_o,
  input logic [DATA_W-1:0]  acc_o,
  input logic [DATA_W-1:0]  pc_o,
  input logic [NUM_OPS-1:0] field_q
);

  logic [IDX_W:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1'b1;
    else             busy_run <= '0;
  end

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_run == (IDX_W+1)'(NUM_OPS)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> ($stable(acc_o) && $stable(pc_o)));

  // R11
  field_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(field_q));

endmodule

bind opsq_top opsq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .acc_o   (acc_o),
  .pc_o    (pc_o),
  .field_q (field_q)
);

// File: tb/opsq_top_tb_top.sv
module opsq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 14;
  localparam int FW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [FW-1:0] field_i;
  logic [DW-1:0] acc_i, pc_i, link_i;
  logic          busy_o, done_o;
  logic [DW-1:0] acc_o, pc_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opsq_top #(.DATA_W(DW), .FIELD_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .field_i(field_i),
    .acc_i(acc_i), .pc_i(pc_i), .link_i(link_i),
    .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o), .pc_o(pc_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: apply bits 0..7 in order.
  function automatic logic [2*DW-1:0] model(input logic [FW-1:0] f,
      input logic [DW-1:0] a0, input logic [DW-1:0] p0, input logic [DW-1:0] l);
    logic [DW-1:0] a, p;
    a = a0; p = p0;
    if (f[0] && a[DW-1]) p = p + 1'b1;
    if (f[1] && a == '0)  p = p + 1'b1;
    if (f[2]) a = '0;
    if (f[3]) a = ~a;
    if (f[4]) a = a + 1'b1;
    if (f[5]) a = a << 1;
    if (f[6]) a = a >> 1;
    if (f[7]) p = l;
    return {a, p};
  endfunction

  // Runs one instruction; if meddle, pulses start with other data mid-scan.
  task automatic run(input string req, input logic [FW-1:0] f, input logic [DW-1:0] a,
                     input logic [DW-1:0] p, input logic [DW-1:0] l, input bit meddle);
    logic [2*DW-1:0] exp;
    exp = model(f, a, p, l);
    @(negedge clk);
    start_i = 1'b1; field_i = f; acc_i = a; pc_i = p; link_i = l;
    @(negedge clk);
    start_i = 1'b0;
    check({req, " R2 busy after start"}, 32'(busy_o), 32'd1);
    for (int k = 1; k < 8; k++) begin
      if (meddle && (k == 2 || k == 3)) begin
        start_i = 1'b1; field_i = ~f; acc_i = ~a; pc_i = ~p; link_i = ~l;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      if (busy_o !== 1'b1 || done_o !== 1'b0)
        check({req, " R2 busy window"}, {30'd0, busy_o, done_o}, 32'd2);
    end
    start_i = 1'b0;
    @(negedge clk);
    check({req, " R2 done pulse"}, {30'd0, busy_o, done_o}, 32'd1);
    check({req, " acc"}, 32'(acc_o), 32'(exp[2*DW-1:DW]));
    check({req, " pc"},  32'(pc_o),  32'(exp[DW-1:0]));
    repeat (2) @(negedge clk);
    check({req, " R12 done single/hold"}, {30'd0, busy_o, done_o}, 32'd0);
    check({req, " R12 hold"}, {acc_o, pc_o}, 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [2*DW-1:0] e;
    rst_n = 1'b0; start_i = 1'b0; field_i = '0;
    acc_i = '0; pc_i = '0; link_i = '0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", {acc_o, pc_o, 2'b00, busy_o, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run("R12 zero field", 11'h000, 14'h1234, 14'h0100, 14'h0200, 1'b0);
    run("R3 neg skip",    11'h001, 14'h2000, 14'h0010, 14'h0000, 1'b0);
    run("R3 no skip",     11'h001, 14'h1FFF, 14'h0010, 14'h0000, 1'b0);
    run("R4 zero skip",   11'h002, 14'h0000, 14'h3FFF, 14'h0000, 1'b0);
    run("R4 no skip",     11'h002, 14'h0001, 14'h0020, 14'h0000, 1'b0);
    run("R5 clear",       11'h004, 14'h2ABC, 14'h0000, 14'h0000, 1'b0);
    run("R5 complement",  11'h008, 14'h0F0F, 14'h0000, 14'h0000, 1'b0);
    run("R6 incr wrap",   11'h010, 14'h3FFF, 14'h0001, 14'h0000, 1'b0);
    run("R7 shl",         11'h020, 14'h3001, 14'h0000, 14'h0000, 1'b0);
    run("R7 shr",         11'h040, 14'h2003, 14'h0000, 14'h0000, 1'b0);
    run("R8 return",      11'h081, 14'h2000, 14'h0050, 14'h0777, 1'b0);
    run("R9 clr+cma+iac", 11'h01C, 14'h1111, 14'h0000, 14'h0000, 1'b0);
    run("R9 zero test before clear", 11'h006, 14'h0005, 14'h0008, 14'h0000, 1'b0);
    run("R10 upper bits", 11'h700, 14'h1357, 14'h0246, 14'h0999, 1'b0);
    run("R11 start ignored", 11'h031, 14'h2222, 14'h0040, 14'h0abc, 1'b1);

    seed = 32'd20240611;
    void'($urandom(seed));
    for (int n = 0; n < 40; n++) begin
      run("R9 random", FW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom),
          (n % 5) == 0);
    end

    // R12: idle cycles without start leave outputs unchanged
    e = {acc_o, pc_o};
    start_i = 1'b0; field_i = 11'h7FF; acc_i = 14'h0; pc_i = 14'h0;
    repeat (5) @(negedge clk);
    check("R12 idle hold", {acc_o, pc_o}, 32'(e));

    // R1: asynchronous reset clears outputs
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {acc_o, pc_o, 2'b00, busy_o, done_o}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule